// File: doc/BRIEF.md
# Strapped-Address I2C Target

This block is a target (slave) for an I2C-compatible two-wire bus, running entirely in a fast system-clock domain. It takes the raw SCL and SDA levels, resynchronises and filters them, and recognises START, repeated START and STOP conditions. It also recognises the rising and falling edges of SCL. Its 7-bit device address is one of four fixed, non-contiguous values, chosen by two strap inputs, so that several such targets can share one bus. It pulls SDA low only through an open-drain enable, and only to acknowledge a byte or to present a zero bit of read data. Every change of that enable waits a configurable number of system clocks after the SCL falling edge.

Behind the bus side sits a small register bank. A write transfer first sets a byte-wide register pointer, and each following byte is written at the pointer, which then increments. A read transfer returns the register at the pointer and increments the pointer after each byte, until the master answers with a NACK. The pointer, the write strobe with its data, and the read data of the bank are visible at the ports.

The system clock must run at least 20 times faster than SCL. The chip's reset logic must release the asynchronous reset synchronously to the system clock.

Top module: `strap_i2c_target`

## Requirements
- R1: The 7-bit device address follows `strap_sel` = {A1,A0}: 2'b00 gives 0x33, 2'b01 gives 0x3B, 2'b10 gives 0x53, 2'b11 gives 0x57. An address byte whose upper seven bits match is acknowledged: SDA is held low during the ninth clock.
- R2: If the address byte does not match, there is no ACK. SDA stays released, and the bus is ignored (no pointer load, no write) until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one in the middle of a byte abandons that byte without writing it. The transfer after a new START works normally.
- R4: A repeated START (a START with no STOP before it) is accepted and restarts address matching. It is how a write of the pointer is followed by a read.
- R5: `sda_pd_o` is high only while the target is acknowledging a received byte or presenting a zero read-data bit. At all other times it is low.
- R6: Bytes are 8 bits, most significant bit first. Bit 0 of the address byte is the direction (1 = read). Each byte is followed by a ninth acknowledge clock.
- R7: In a write transfer, the first data byte loads `reg_ptr_o`. Each later byte gives a one-cycle `wr_stb_o` pulse with the byte on `wr_data_o` and the target register on `reg_ptr_o`, and the pointer then increments by one.
- R8: In a read transfer, each byte sent is the register at the pointer, and the pointer increments after each byte. The bank register selected is the pointer modulo NREGS.
- R9: A NACK from the master on a read byte ends the read. SDA stays released through any further clocks until the next START.
- R10: A change of `sda_pd_o` caused by a bus transfer happens no sooner than HOLD_CYC system clocks after the filtered SCL falling edge. Only a START or a STOP releases SDA at once.
- R11: A pulse of one system clock on SCL or on SDA is ignored and does not disturb a transfer in progress.
- R12: After reset, `sda_pd_o` and `wr_stb_o` are low, `reg_ptr_o` is 0 and every bank register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 2 | Address strap {A1,A0} |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| reg_ptr_o | output | 8 | Current register pointer |
| wr_stb_o | output | 1 | One-cycle write strobe into the register bank |
| wr_data_o | output | 8 | Byte written while wr_stb_o is high |
| rd_data_o | output | 8 | Bank register at the pointer, source of read bytes |

## Verification
The bench builds the target with HOLD_CYC=6 and NREGS=4, and runs a bus master whose quarter SCL period is 25 system clocks. The short hold leaves the delayed SDA change well inside the SCL low phase, so the distance from the SCL fall to the ACK edge can be measured exactly against the parameter. The four-register bank lets a write burst carry the pointer past the end of the bank. A read-back then shows the modulo wrap to register 0 without long bursts.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;

  // strap {A1,A0} to 7-bit device address
  function automatic logic [6:0] strap_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'h33;
      2'b01:   return 7'h3B;
      2'b10:   return 7'h53;
      default: return 7'h57;
    endcase
  endfunction

endpackage

// File: rtl/strap_i2c_line_filt.sv
module strap_i2c_line_filt #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic sync1_q, sync2_q, samp_q, filt_q;
  logic filt_d;

  // accept a new level only after two equal consecutive samples
  always_comb begin
    filt_d = filt_q;
    if (sync2_q == samp_q) filt_d = samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= IDLE_VAL;
      sync2_q <= IDLE_VAL;
      samp_q  <= IDLE_VAL;
      filt_q  <= IDLE_VAL;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      samp_q  <= sync2_q;
      filt_q  <= filt_d;
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/strap_i2c_proto.sv
module strap_i2c_proto
  import strap_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_want,
  output logic              bus_rel,
  output logic              scl_fall,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

  logic scl_q, sda_q;
  logic scl_rise, start_c, stop_c;

  tgt_state_e        state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] txreg_q, txreg_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              rnw_q, rnw_d;
  logic              first_q, first_d;
  logic              mack_q, mack_d;
  logic              want_q, want_d;
  logic              stb_q, stb_d;

  // bus conditions on the filtered lines
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign bus_rel  = start_c | stop_c;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    txreg_d = txreg_q;
    ptr_d   = ptr_q;
    wdat_d  = wdat_q;
    rnw_d   = rnw_q;
    first_d = first_q;
    mack_d  = mack_q;
    want_d  = want_q;
    stb_d   = 1'b0;

    if (stb_q) ptr_d = ptr_q + 1'b1;

    if (start_c) begin
      state_d = ST_ADDR;
      bcnt_d  = '0;
      want_d  = 1'b0;
    end else if (stop_c) begin
      state_d = ST_IDLE;
      bcnt_d  = '0;
      want_d  = 1'b0;
    end else begin
      if (scl_rise) begin
        case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            shreg_d = {shreg_q[BYTE_W-2:0], sda_f};
            bcnt_d  = bcnt_q + 1'b1;
          end
          ST_RD_BYTE: bcnt_d = bcnt_q + 1'b1;
          ST_RD_ACK:  mack_d = ~sda_f;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state_q)
          ST_ADDR: begin
            if (bcnt_q == LAST_BIT) begin
              if (shreg_q[BYTE_W-1:1] == dev_addr) begin
                state_d = ST_ADDR_ACK;
                want_d  = 1'b1;
                rnw_d   = shreg_q[0];
                first_d = 1'b1;
              end else begin
                state_d = ST_SKIP;
                want_d  = 1'b0;
              end
            end
          end
          ST_ADDR_ACK: begin
            bcnt_d = '0;
            if (rnw_q) begin
              txreg_d = rd_data;
              want_d  = ~rd_data[BYTE_W-1];
              state_d = ST_RD_BYTE;
            end else begin
              want_d  = 1'b0;
              state_d = ST_WR_BYTE;
            end
          end
          ST_WR_BYTE: begin
            if (bcnt_q == LAST_BIT) begin
              state_d = ST_WR_ACK;
              want_d  = 1'b1;
              if (first_q) begin
                ptr_d   = shreg_q;
                first_d = 1'b0;
              end else begin
                stb_d  = 1'b1;
                wdat_d = shreg_q;
              end
            end
          end
          ST_WR_ACK: begin
            want_d  = 1'b0;
            bcnt_d  = '0;
            state_d = ST_WR_BYTE;
          end
          ST_RD_BYTE: begin
            if (bcnt_q == LAST_BIT) begin
              want_d  = 1'b0;
              state_d = ST_RD_ACK;
              ptr_d   = ptr_q + 1'b1;
            end else if (bcnt_q != '0) begin
              txreg_d = {txreg_q[BYTE_W-2:0], 1'b0};
              want_d  = ~txreg_q[BYTE_W-2];
            end
          end
          ST_RD_ACK: begin
            if (mack_q) begin
              txreg_d = rd_data;
              want_d  = ~rd_data[BYTE_W-1];
              bcnt_d  = '0;
              state_d = ST_RD_BYTE;
            end else begin
              state_d = ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shreg_q <= '0;
      txreg_q <= '0;
      ptr_q   <= '0;
      wdat_q  <= '0;
      rnw_q   <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      want_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      txreg_q <= txreg_d;
      ptr_q   <= ptr_d;
      wdat_q  <= wdat_d;
      rnw_q   <= rnw_d;
      first_q <= first_d;
      mack_q  <= mack_d;
      want_q  <= want_d;
      stb_q   <= stb_d;
    end
  end

  assign sda_want = want_q;
  assign reg_ptr  = ptr_q;
  assign wr_stb   = stb_q;
  assign wr_data  = wdat_q;

  // R5
  sda_drive_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    want_q |-> (state_q inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD_BYTE}));

  // R7
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R3
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state_q == ST_ADDR && bcnt_q == '0 && !want_q));

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state_q == ST_IDLE && !want_q));

endmodule

// File: rtl/strap_i2c_sda_hold.sv
module strap_i2c_sda_hold #(
  parameter int HOLD_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic rel_i,
  input  logic want_i,
  output logic pd_o
);

  localparam int              CNT_W   = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pd_q, pd_d;

  always_comb begin
    cnt_d = cnt_q;
    pd_d  = pd_q;
    if (rel_i) begin
      cnt_d = '0;
      pd_d  = 1'b0;
    end else if (fall_i) begin
      cnt_d = HOLD_LD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      pd_d = want_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pd_q  <= pd_d;
    end
  end

  assign pd_o = pd_q;

endmodule

// File: rtl/strap_i2c_regbank.sv
module strap_i2c_regbank #(
  parameter int NREGS  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wr_data;
    end
  end

  assign rd_data = regs_q[idx];

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import strap_i2c_pkg::*;
#(
  parameter int HOLD_CYC = 75,
  parameter int NREGS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  output logic [7:0] reg_ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_data_o
);

  localparam int IDX_W   = $clog2(NREGS);
  localparam int SINCE_W = $clog2(HOLD_CYC + 2) + 1;

  logic [1:0] raw_lines, filt_lines;
  logic       sda_want, bus_rel, scl_fall;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    strap_i2c_line_filt #(.IDLE_VAL(1'b1)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[i]),
      .line_o (filt_lines[i])
    );
  end

  strap_i2c_proto u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .dev_addr (strap_addr(strap_sel)),
    .rd_data  (rd_data_o),
    .sda_want (sda_want),
    .bus_rel  (bus_rel),
    .scl_fall (scl_fall),
    .reg_ptr  (reg_ptr_o),
    .wr_stb   (wr_stb_o),
    .wr_data  (wr_data_o)
  );

  strap_i2c_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .fall_i (scl_fall),
    .rel_i  (bus_rel),
    .want_i (sda_want),
    .pd_o   (sda_pd_o)
  );

  strap_i2c_regbank #(.NREGS(NREGS), .DATA_W(BYTE_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (reg_ptr_o[IDX_W-1:0]),
    .wr_en   (wr_stb_o),
    .wr_data (wr_data_o),
    .rd_data (rd_data_o)
  );

  // cycles since the last filtered SCL fall, saturating, for the hold check
  logic [SINCE_W-1:0] since_fall_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        since_fall_q <= '0;
    else if (scl_fall)                                 since_fall_q <= '0;
    else if (since_fall_q != SINCE_W'(HOLD_CYC + 1))   since_fall_q <= since_fall_q + 1'b1;
  end

  // R10
  hold_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pd_o) && !$past(bus_rel)) |-> (since_fall_q > SINCE_W'(HOLD_CYC)));

endmodule

// File: tb/strap_i2c_target_tb.sv
module strap_i2c_target_tb;

  localparam int TB_HOLD  = 6;
  localparam int TB_NREGS = 4;
  localparam int Q        = 25;

  logic       clk;
  logic       rst_n;
  logic [1:0] strap_sel;
  logic       scl_m;
  logic       m_sda_low;
  logic       sda_line;
  logic       sda_pd_o;
  logic [7:0] reg_ptr_o;
  logic       wr_stb_o;
  logic [7:0] wr_data_o;
  logic [7:0] rd_data_o;

  int nchk = 0;
  int nerr = 0;
  int stb_cnt = 0;
  logic [7:0] last_wr_data;
  logic [7:0] last_wr_ptr;
  logic       pd_seen;

  assign sda_line = ~(m_sda_low | sda_pd_o);

  strap_i2c_target #(.HOLD_CYC(TB_HOLD), .NREGS(TB_NREGS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_sel (strap_sel),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_pd_o  (sda_pd_o),
    .reg_ptr_o (reg_ptr_o),
    .wr_stb_o  (wr_stb_o),
    .wr_data_o (wr_data_o),
    .rd_data_o (rd_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      stb_cnt      = stb_cnt + 1;
      last_wr_data = wr_data_o;
      last_wr_ptr  = reg_ptr_o;
    end
    if (rst_n && sda_pd_o) pd_seen = 1'b1;
  end

  function automatic logic [6:0] exp_addr(input int s);
    case (s)
      0: return 7'h33;
      1: return 7'h3B;
      2: return 7'h53;
      default: return 7'h57;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b1; wcyc(2*Q);
    scl_m = 1'b0;     wcyc(Q);
  endtask

  task automatic bus_rstart;
    m_sda_low = 1'b0; wcyc(Q);
    scl_m = 1'b1;     wcyc(Q);
    m_sda_low = 1'b1; wcyc(Q);
    scl_m = 1'b0;     wcyc(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; wcyc(Q);
    scl_m = 1'b1;     wcyc(Q);
    m_sda_low = 1'b0; wcyc(2*Q);
  endtask

  task automatic bus_bit(input logic b, output logic smp);
    m_sda_low = ~b; wcyc(Q);
    scl_m = 1'b1;   wcyc(Q);
    smp = sda_line; wcyc(Q);
    scl_m = 1'b0;   wcyc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~mack, s);
  endtask

  task automatic t_reset;
    check("R12 pd after reset", sda_pd_o, 0);
    check("R12 ptr after reset", reg_ptr_o, 0);
    check("R12 strobe after reset", wr_stb_o, 0);
  endtask

  task automatic t_straps;
    logic ack;
    for (int s = 0; s < 4; s++) begin
      strap_sel = 2'(s);
      wcyc(4);
      bus_start;
      wr_byte({exp_addr(s), 1'b0}, ack);
      check($sformatf("R1 R6 ack for strap %0d", s), ack, 1);
      bus_stop;
    end
  endtask

  task automatic t_mismatch;
    logic ack;
    strap_sel = 2'b00;
    wcyc(4);
    pd_seen = 1'b0;
    bus_start;
    wr_byte({7'h3B, 1'b0}, ack);
    check("R2 no ack for foreign address", ack, 0);
    wr_byte(8'h42, ack);
    check("R2 no ack for ignored byte", ack, 0);
    bus_stop;
    check("R2 pointer untouched", reg_ptr_o, 0);
    check("R2 R5 sda never driven", pd_seen, 0);
  endtask

  task automatic t_write;
    logic ack;
    int   c0;
    strap_sel = 2'b10;
    wcyc(4);
    c0 = stb_cnt;
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h01, ack);
    check("R7 pointer byte acked", ack, 1);
    check("R7 pointer loaded", reg_ptr_o, 8'h01);
    wr_byte(8'hA5, ack);
    wr_byte(8'h3C, ack);
    check("R7 data acked", ack, 1);
    bus_stop;
    check("R7 strobe count", stb_cnt - c0, 2);
    check("R7 last data", last_wr_data, 8'h3C);
    check("R7 last target", last_wr_ptr, 8'h02);
    check("R7 pointer after burst", reg_ptr_o, 8'h03);
  endtask

  task automatic t_read;
    logic ack, s;
    logic [7:0] b;
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h01, ack);
    bus_rstart;
    wr_byte(8'hA7, ack);
    check("R4 repeated start read address acked", ack, 1);
    rd_byte(1'b1, b);
    check("R8 R6 read byte 0", b, 8'hA5);
    rd_byte(1'b1, b);
    check("R8 read byte 1", b, 8'h3C);
    rd_byte(1'b0, b);
    check("R8 read unwritten reg", b, 8'h00);
    check("R8 pointer after read", reg_ptr_o, 8'h04);
    pd_seen = 1'b0;
    for (int i = 0; i < 9; i++) bus_bit(1'b1, s);
    check("R9 released after nack", pd_seen, 0);
    bus_stop;
  endtask

  task automatic t_wrap;
    logic ack;
    logic [7:0] b;
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h03, ack);
    wr_byte(8'h77, ack);
    wr_byte(8'h88, ack);
    bus_stop;
    check("R7 strobe target past bank end", last_wr_ptr, 8'h04);
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h00, ack);
    bus_rstart;
    wr_byte(8'hA7, ack);
    rd_byte(1'b0, b);
    check("R8 pointer 4 wrapped to reg 0", b, 8'h88);
    bus_stop;
  endtask

  task automatic t_abort;
    logic ack, s;
    int   c0;
    c0 = stb_cnt;
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h02, ack);
    bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
    bus_stop;
    check("R3 stop mid byte no write", stb_cnt - c0, 0);
    check("R3 pointer kept", reg_ptr_o, 8'h02);
    bus_start;
    bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
    bus_rstart;
    wr_byte(8'hA6, ack);
    check("R3 start mid byte then new address acked", ack, 1);
    bus_stop;
  endtask

  task automatic t_hold;
    logic s;
    int   n;
    bus_start;
    for (int i = 7; i >= 1; i--) bus_bit(8'hA6 >> i, s);
    m_sda_low = 1'b1; wcyc(Q);
    scl_m = 1'b1;     wcyc(2*Q);
    scl_m = 1'b0;
    n = 0;
    while (!sda_pd_o && n < 2*Q) begin
      @(negedge clk);
      n++;
    end
    check("R10 ack not before hold", (n >= TB_HOLD + 1) ? 1 : 0, 1);
    check("R10 ack within low phase", (n <= TB_HOLD + 6) ? 1 : 0, 1);
    wcyc(Q);
    bus_bit(1'b1, s);
    check("R1 ack after hold", s, 0);
    bus_stop;
  endtask

  task automatic t_glitch;
    logic ack;
    int   c0;
    logic [7:0] d;
    d  = 8'h5A;
    c0 = stb_cnt;
    bus_start;
    wr_byte(8'hA6, ack);
    wr_byte(8'h00, ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~d[i]; wcyc(10);
      scl_m = 1'b1;      wcyc(1);
      scl_m = 1'b0;      wcyc(Q - 11);
      scl_m = 1'b1;      wcyc(10);
      m_sda_low = d[i];  wcyc(1);
      m_sda_low = ~d[i]; wcyc(2*Q - 11);
      scl_m = 1'b0;      wcyc(Q);
    end
    begin
      logic s;
      bus_bit(1'b1, s);
      ack = ~s;
    end
    check("R11 glitched byte acked", ack, 1);
    bus_stop;
    check("R11 one write", stb_cnt - c0, 1);
    check("R11 data intact", last_wr_data, 8'h5A);
  endtask

  initial begin
    rst_n     = 1'b0;
    strap_sel = 2'b00;
    scl_m     = 1'b1;
    m_sda_low = 1'b0;
    pd_seen   = 1'b0;
    last_wr_data = '0;
    last_wr_ptr  = '0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset;
    t_straps;
    t_mismatch;
    t_write;
    t_read;
    t_wrap;
    t_abort;
    t_hold;
    t_glitch;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule